// File: doc/BRIEF.md
# Sequenced RGB Colour Lookup Front End

This block puts a colour lookup table on a simple 32-bit register bus. The table holds a main bank of 256 entries and a small overlay bank of 4 entries. Each entry stores red, green and blue bytes. Software selects an entry by writing an index register. It then moves a colour in or out one byte at a time. An internal phase counter steps through red, green and blue. After the blue byte the index moves on to the next entry, so a run of accesses can walk the whole table.

The byte being moved always sits in the top byte of the data word. The overlay bank has its own data offset. It takes its entry from the two low bits of the shared index. A separate combinational port turns a pixel index into a 24-bit colour for the pixel pipeline. The analog converter and the video timing sit outside this block.

Top module: `clut_dac_if`

## Requirements
- R1: A valid write at byte offset 0 loads the index from wdata bits 31:24 and sets the phase to red (phase codes: red=0, green=1, blue=2). This also applies in the middle of a red/green/blue sequence.
- R2: A valid write at offset 4 stores wdata bits 31:24 into the current phase's component of main entry [index].
- R3: A valid write at offset 12 stores into overlay entry 256 + (index & 3), using the same phase sequence and the same index advance.
- R4: Each data access moves the phase red, then green, then blue. The access that handles blue increments the index modulo 256 and returns the phase to red.
- R5: A valid read, at any offset, returns the current phase's component of main entry [index] in rdata bits 31:24 with bits 23:0 zero. It advances the phase and index exactly as a data write does. When there is no valid read, rdata is zero.
- R6: After reset, every component is zero except entries 255, 256 and 258, which are white (FF,FF,FF). The index and phase are cleared.
- R7: Writes at any other offset (for example offset 8) change no entry, the phase or the index. Only full-word accesses (be_i = 4'b1111) count. Any other access is ignored and a read of that kind returns zero.
- R8: lut_rgb_o = {R,G,B} of entry lut_idx_i, with no register in the path, for indices 0 to 259. A table write shows there from the cycle after the write. An index of 260 or above gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset of the access |
| be_i | input | 4 | Byte enables; only 4'b1111 is a valid access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational during a read |
| lut_idx_i | input | 9 | Pixel index for the lookup port |
| lut_rgb_o | output | 24 | Colour {R,G,B} for lut_idx_i |

## Verification
Several rules are checked by assertions on every cycle. The index register must follow an index load. The phase must never take an illegal code. The index must step only when a blue access completes. Partial-width accesses must leave the index and phase unchanged.

Other behaviour shows only in the bench scenarios, because it depends on the stored contents. This covers which component and entry a byte lands in, the wrap from entry 255 to 0, overlay selection from the low index bits, readback order, the reset colours, and ignored control writes.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    PH_R = 2'd0,
    PH_G = 2'd1,
    PH_B = 2'd2
  } phase_e;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output phase_e           ph_o
);
  logic [IDX_W-1:0] idx_q;
  phase_e           ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ph_q  <= PH_R;
    end else if (load_i) begin
      idx_q <= load_val_i;
      ph_q  <= PH_R;
    end else if (step_i) begin
      unique case (ph_q)
        PH_R:    ph_q <= PH_G;
        PH_G:    ph_q <= PH_B;
        default: begin
          ph_q  <= PH_R;
          idx_q <= idx_q + 1'b1;
        end
      endcase
    end
  end

  assign idx_o = idx_q;
  assign ph_o  = ph_q;

  assert_addr_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (idx_q == $past(load_val_i)) && (ph_q == PH_R));

  assert_phase_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q != 2'd3);

  assert_idx_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && ph_q == PH_B) |=> idx_q == $past(idx_q) + 1'b1);

  assert_idx_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(step_i && ph_q == PH_B)) |=> $stable(idx_q));
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int MAIN_N = 256,
  parameter int OVL_N  = 4,
  parameter int CMP_W  = 8,
  parameter int LUT_W  = 9,
  parameter int IDX_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [LUT_W-1:0]   waddr_i,
  input  phase_e             wph_i,
  input  logic [CMP_W-1:0]   wbyte_i,
  input  logic [IDX_W-1:0]   raddr_i,
  input  phase_e             rph_i,
  output logic [CMP_W-1:0]   rbyte_o,
  input  logic [LUT_W-1:0]   lut_idx_i,
  output logic [3*CMP_W-1:0] lut_rgb_o
);
  localparam int TOT_N = MAIN_N + OVL_N;

  logic [CMP_W-1:0] mem_r [TOT_N];
  logic [CMP_W-1:0] mem_g [TOT_N];
  logic [CMP_W-1:0] mem_b [TOT_N];

  for (genvar e = 0; e < TOT_N; e++) begin : g_ent
    localparam bit WHITE = (e == MAIN_N - 1) || (e == MAIN_N) || (e == MAIN_N + 2);
    localparam logic [CMP_W-1:0] RST_V = WHITE ? {CMP_W{1'b1}} : '0;
    logic hit;
    assign hit = we_i && (int'(waddr_i) == e);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_r[e] <= RST_V;
        mem_g[e] <= RST_V;
        mem_b[e] <= RST_V;
      end else if (hit) begin
        unique case (wph_i)
          PH_R:    mem_r[e] <= wbyte_i;
          PH_G:    mem_g[e] <= wbyte_i;
          default: mem_b[e] <= wbyte_i;
        endcase
      end
    end
  end

  always_comb begin
    unique case (rph_i)
      PH_R:    rbyte_o = mem_r[raddr_i];
      PH_G:    rbyte_o = mem_g[raddr_i];
      default: rbyte_o = mem_b[raddr_i];
    endcase
  end

  always_comb begin
    lut_rgb_o = '0;
    if (int'(lut_idx_i) < TOT_N)
      lut_rgb_o = {mem_r[lut_idx_i], mem_g[lut_idx_i], mem_b[lut_idx_i]};
  end
endmodule

// File: rtl/clut_dac_if.sv
module clut_dac_if
  import clut_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int CMP_W  = 8,
  parameter int MAIN_N = 256,
  parameter int OVL_N  = 4,
  parameter logic [ADDR_W-1:0] OFF_IDX = 4'd0,
  parameter logic [ADDR_W-1:0] OFF_PAL = 4'd4,
  parameter logic [ADDR_W-1:0] OFF_OVL = 4'd12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [$clog2(MAIN_N+OVL_N)-1:0] lut_idx_i,
  output logic [3*CMP_W-1:0]  lut_rgb_o
);
  localparam int TOT_N = MAIN_N + OVL_N;
  localparam int IDX_W = $clog2(MAIN_N);
  localparam int LUT_W = $clog2(TOT_N);
  localparam int OVL_W = $clog2(OVL_N);

  logic             acc_ok, ld, pal_wr, rd, step;
  logic [IDX_W-1:0] idx;
  phase_e           ph;
  logic [LUT_W-1:0] waddr;
  logic [CMP_W-1:0] rbyte;
  logic [CMP_W-1:0] top_byte;

  assign acc_ok   = req_i && (be_i == '1);
  assign ld       = acc_ok && we_i && (addr_i == OFF_IDX);
  assign pal_wr   = acc_ok && we_i && ((addr_i == OFF_PAL) || (addr_i == OFF_OVL));
  assign rd       = acc_ok && !we_i;
  assign step     = pal_wr || rd;
  assign top_byte = wdata_i[DATA_W-1 -: CMP_W];

  // overlay bank indexed by low index bits only
  assign waddr = (addr_i == OFF_OVL)
               ? LUT_W'(MAIN_N) + LUT_W'(idx[OVL_W-1:0])
               : LUT_W'(idx);

  clut_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ld),
    .load_val_i (wdata_i[DATA_W-1 -: IDX_W]),
    .step_i     (step),
    .idx_o      (idx),
    .ph_o       (ph)
  );

  clut_store #(
    .MAIN_N (MAIN_N),
    .OVL_N  (OVL_N),
    .CMP_W  (CMP_W),
    .LUT_W  (LUT_W),
    .IDX_W  (IDX_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (pal_wr),
    .waddr_i   (waddr),
    .wph_i     (ph),
    .wbyte_i   (top_byte),
    .raddr_i   (idx),
    .rph_i     (ph),
    .rbyte_o   (rbyte),
    .lut_idx_i (lut_idx_i),
    .lut_rgb_o (lut_rgb_o)
  );

  assign rdata_o = rd ? {rbyte, {(DATA_W-CMP_W){1'b0}}} : '0;

  assert_partial_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && be_i != '1) |=> $stable(idx) && $stable(ph));

  assert_ctrl_wr_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i != OFF_IDX && addr_i != OFF_PAL && addr_i != OFF_OVL)
    |=> $stable(idx) && $stable(ph));

  assert_read_low_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-CMP_W-1:0] == '0);
endmodule

// File: tb/clut_dac_if_bench.sv
module clut_dac_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0, be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [8:0]  lut_idx = '0;
  logic [23:0] lut_rgb;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  clut_dac_if u_clut_dac_if (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata),
    .lut_idx_i(lut_idx), .lut_rgb_o(lut_rgb)
  );

  task automatic bus(input logic w, input logic [3:0] off, input logic [31:0] d,
                     input logic [3:0] b, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = w; addr = off; wdata = d; be = b;
    if (!w) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] off, input logic [31:0] d);
    bus(1'b1, off, d, 4'hF, '0, "");
  endtask

  task automatic rd(input logic [31:0] exp, input string tag);
    bus(1'b0, 4'd4, 32'h0, 4'hF, exp, tag);
  endtask

  task automatic chk_lut(input int idx, input logic [23:0] exp, input string tag);
    lut_idx = 9'(idx);
    #1;
    n_chk++;
    if (lut_rgb !== exp) begin
      n_bad++;
      $display("FAIL %s lut[%0d] actual=%h expected=%h", tag, idx, lut_rgb, exp);
    end
  endtask

  // monitor: compare read data in the cycle the read is presented
  initial forever begin
    @(negedge clk);
    #5;
    if (req && !we) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R5 unexpected read actual=%h expected=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s read actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    #2000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6 reset defaults
    chk_lut(0,   24'h000000, "R6");
    chk_lut(255, 24'hFFFFFF, "R6");
    chk_lut(256, 24'hFFFFFF, "R6");
    chk_lut(257, 24'h000000, "R6");
    chk_lut(258, 24'hFFFFFF, "R6");
    chk_lut(259, 24'h000000, "R6");
    rd(32'h0, "R6_idx0");
    // R2 R4 data writes with autoincrement
    wr(4'd0, 32'h05ABCDEF);
    wr(4'd4, 32'h11000001); wr(4'd4, 32'h22FFFFFF); wr(4'd4, 32'h33000000);
    @(negedge clk); chk_lut(5, 24'h112233, "R2");
    wr(4'd4, 32'h44000000); wr(4'd4, 32'h55000000); wr(4'd4, 32'h66000000);
    @(negedge clk); chk_lut(6, 24'h445566, "R4");
    // R5 readback advances phase and index
    wr(4'd0, 32'h05000000);
    rd(32'h11000000, "R5"); rd(32'h22000000, "R5"); rd(32'h33000000, "R5");
    rd(32'h44000000, "R5"); rd(32'h55000000, "R5");
    // R4 wrap at 255
    wr(4'd0, 32'hFF000000);
    wr(4'd4, 32'hAA000000); wr(4'd4, 32'hBB000000); wr(4'd4, 32'hCC000000);
    wr(4'd4, 32'h01000000); wr(4'd4, 32'h02000000); wr(4'd4, 32'h03000000);
    @(negedge clk);
    chk_lut(255, 24'hAABBCC, "R4");
    chk_lut(0,   24'h010203, "R4_wrap");
    // R3 overlay bank
    wr(4'd0, 32'h07000000);
    wr(4'd12, 32'hDE000000); wr(4'd12, 32'hAD000000); wr(4'd12, 32'hBE000000);
    wr(4'd12, 32'h10000000); wr(4'd12, 32'h20000000); wr(4'd12, 32'h30000000);
    @(negedge clk);
    chk_lut(259, 24'hDEADBE, "R3");
    chk_lut(256, 24'h102030, "R3");
    chk_lut(7,   24'h000000, "R3");
    chk_lut(8,   24'h000000, "R3");
    // R1 index write mid-sequence restarts at red
    wr(4'd0, 32'h09000000);
    wr(4'd4, 32'h77000000);
    wr(4'd0, 32'h09000000);
    wr(4'd4, 32'h88000000); wr(4'd4, 32'h99000000); wr(4'd4, 32'hAA000000);
    @(negedge clk); chk_lut(9, 24'h8899AA, "R1");
    // R7 control offset and partial accesses ignored
    wr(4'd0, 32'h0A000000);
    wr(4'd4, 32'h12000000);
    wr(4'd8, 32'hFF000000);
    bus(1'b1, 4'd4, 32'hEE000000, 4'h3, '0, "");
    bus(1'b0, 4'd4, 32'h0, 4'hC, 32'h0, "R7_partial_rd");
    wr(4'd4, 32'h34000000); wr(4'd4, 32'h56000000);
    @(negedge clk);
    chk_lut(10, 24'h123456, "R7");
    chk_lut(11, 24'h000000, "R7");
    // R8 out-of-range lookup and next-cycle visibility
    chk_lut(300, 24'h000000, "R8");
    chk_lut(511, 24'h000000, "R8");
    wr(4'd0, 32'h14000000);
    wr(4'd4, 32'h5A000000);
    chk_lut(20, 24'h5A0000, "R8");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R5 pending reads actual=%0d expected=0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule